// File: doc/BRIEF.md
# Removal Confidence Predictor Table

This block is a prediction table for the leading, shortened stream of a redundant dual-stream processor. For every basic block that the leading stream fetches, it supplies two answers: the predicted direction of the branch that closes the block, and a 16-bit mask of the block's instruction slots that may be skipped. Entries are selected by hashing the block's start PC with a global branch history register. The table keeps that register itself.

The detector that watches retired instructions of the trailing stream trains the table. It sends back the block start PC, the history value that was in use at lookup time, the real branch outcome, and a per-slot removability mask. Each entry holds a tag, a 2-bit direction counter, and one saturating confidence counter per slot. A slot is reported removable only after many consecutive removable reports. Any report that a slot is not removable sets its counter back to zero. A lookup returns the history value it used, so that the requester can hand it back on the update.

Top module: `rcp_top`

## Requirements
- R1: After reset every entry is invalid, the global history is zero, and `rsp_valid` is low until a lookup is made.
- R2: A lookup presented on `lkp_valid` is answered on the next clock cycle with `rsp_valid` high. `rsp_hist` carries the global history value that the lookup used.
- R3: The entry index is `pc[IDX_W+1:2]` XOR the low bits of the history: the live global history for lookups and `upd_hist` for updates. An entry hits only when it is valid and its stored tag equals `pc[31:2]`.
- R4: A lookup that misses returns `rsp_hit`=0, `rsp_taken`=1 (weakly taken) and an all-zero skip mask.
- R5: On a hit, `rsp_taken` is the MSB of the entry's 2-bit direction counter. An update that hits moves that counter one step toward the outcome, saturating at 0 and 3.
- R6: An update that misses reallocates the entry. It writes the new tag, clears all sixteen confidence counters, and sets the direction counter to 2 if the outcome was taken or 1 if it was not.
- R7: An update that hits treats bit i of `upd_removable` as belonging to slot i. If the bit is 1, that slot's 7-bit counter is incremented, saturating at 64. If the bit is 0, the counter is cleared to zero.
- R8: On a hit, bit i of `rsp_skip` is 1 exactly when slot i's counter has reached 64. At 63 the bit is 0.
- R9: Every update shifts the global history left by one, with `upd_taken` entering at bit 0.
- R10: A lookup and an update in the same cycle: the lookup sees the table and history as they were before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_pc | input | 32 | Start PC of the fetched basic block |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| rsp_hit | output | 1 | Tag matched a valid entry |
| rsp_taken | output | 1 | Predicted direction of the closing branch |
| rsp_skip | output | 16 | Slots predicted removable |
| rsp_hist | output | HIST_W | Global history used by the lookup |
| upd_valid | input | 1 | Training update from the detector |
| upd_pc | input | 32 | Start PC of the trained block |
| upd_hist | input | HIST_W | History used when the block was looked up |
| upd_taken | input | 1 | Actual outcome of the closing branch |
| upd_removable | input | 16 | Per-slot removability, bit i for slot i |

## Verification
The hardest state to reach from the ports is the confidence threshold itself. It needs sixty-four removable reports in a row for the same entry, and the skip mask has to be observed at 63 and again at 64. The history also moves with every update, so the lookup index would normally drift away from the entry being trained. The stimulus avoids this by training only with not-taken outcomes and a history of zero. Where a taken outcome is needed, a run of not-taken updates to an unrelated block flushes the history back to zero. The final step toward the threshold is issued together with a lookup, which observes the same-cycle ordering. More than sixty further updates then show that the counters do not wrap.

// File: rtl/rcp_pkg.sv
package rcp_pkg;

    localparam int PC_W     = 32;
    localparam int SLOTS    = 16;
    localparam int CONF_W   = 7;
    localparam int CONF_MAX = 64;
    localparam int TAG_W    = PC_W - 2;

    typedef logic [CONF_W-1:0] conf_t;

    typedef struct packed {
        logic                         valid;
        logic [TAG_W-1:0]             tag;
        logic [1:0]                   bctr;
        logic [SLOTS-1:0][CONF_W-1:0] conf;
    } entry_t;

    localparam logic [1:0] BCTR_WEAK_T = 2'b10;
    localparam logic [1:0] BCTR_WEAK_N = 2'b01;

    function automatic logic [TAG_W-1:0] pc_tag(input logic [PC_W-1:0] pc);
        return pc[PC_W-1:2];
    endfunction

    function automatic logic [1:0] bctr_step(input logic [1:0] c, input logic t);
        if (t)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

endpackage

// File: rtl/rcp_hash.sv
module rcp_hash
    import rcp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 6
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        if (i < HIST_W) begin : g_mix
            assign idx[i] = pc[i+2] ^ hist[i];
        end else begin : g_pass
            assign idx[i] = pc[i+2];
        end
    end
endmodule

// File: rtl/rcp_lookup_decode.sv
module rcp_lookup_decode
    import rcp_pkg::*;
(
    input  entry_t           ent,
    input  logic [PC_W-1:0]  pc,
    output logic             hit,
    output logic             taken,
    output logic [SLOTS-1:0] skip
);
    assign hit   = ent.valid && (ent.tag == pc_tag(pc));
    assign taken = hit ? ent.bctr[1] : 1'b1;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign skip[s] = hit && (ent.conf[s] >= conf_t'(CONF_MAX));
    end
endmodule

// File: rtl/rcp_entry_next.sv
module rcp_entry_next
    import rcp_pkg::*;
(
    input  entry_t           cur,
    input  logic             hit,
    input  logic [PC_W-1:0]  pc,
    input  logic             taken,
    input  logic [SLOTS-1:0] removable,
    output entry_t           nxt
);
    logic [SLOTS-1:0][CONF_W-1:0] conf_trained;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        always_comb begin
            if (!removable[s])
                conf_trained[s] = '0;
            else if (cur.conf[s] >= conf_t'(CONF_MAX))
                conf_trained[s] = conf_t'(CONF_MAX);
            else
                conf_trained[s] = cur.conf[s] + conf_t'(1);
        end
    end

    always_comb begin
        nxt.valid = 1'b1;
        nxt.tag   = pc_tag(pc);
        if (hit) begin
            nxt.bctr = bctr_step(cur.bctr, taken);
            nxt.conf = conf_trained;
        end else begin
            nxt.bctr = taken ? BCTR_WEAK_T : BCTR_WEAK_N;
            nxt.conf = '0;
        end
    end
endmodule

// File: rtl/rcp_top.sv
module rcp_top
    import rcp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lkp_valid,
    input  logic [31:0]       lkp_pc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_taken,
    output logic [15:0]       rsp_skip,
    output logic [HIST_W-1:0] rsp_hist,
    input  logic              upd_valid,
    input  logic [31:0]       upd_pc,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken,
    input  logic [15:0]       upd_removable
);
    localparam int DEPTH = 1 << IDX_W;

    entry_t              tbl_q [DEPTH];
    logic [HIST_W-1:0]   ghr_q;

    logic [IDX_W-1:0]    lkp_idx, upd_idx;
    logic                lkp_hit, lkp_taken;
    logic [SLOTS-1:0]    lkp_skip;
    logic                upd_hit, upd_pred_unused;
    logic [SLOTS-1:0]    upd_skip_unused;
    entry_t              upd_next;

    rcp_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_lkp_hash (
        .pc(lkp_pc), .hist(ghr_q), .idx(lkp_idx));

    rcp_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_upd_hash (
        .pc(upd_pc), .hist(upd_hist), .idx(upd_idx));

    rcp_lookup_decode i_lkp_dec (
        .ent(tbl_q[lkp_idx]), .pc(lkp_pc),
        .hit(lkp_hit), .taken(lkp_taken), .skip(lkp_skip));

    rcp_lookup_decode i_upd_dec (
        .ent(tbl_q[upd_idx]), .pc(upd_pc),
        .hit(upd_hit), .taken(upd_pred_unused), .skip(upd_skip_unused));

    rcp_entry_next i_next (
        .cur(tbl_q[upd_idx]), .hit(upd_hit), .pc(upd_pc),
        .taken(upd_taken), .removable(upd_removable), .nxt(upd_next));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
            ghr_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_taken <= 1'b0;
            rsp_skip  <= '0;
            rsp_hist  <= '0;
        end else begin
            rsp_valid <= lkp_valid;
            if (lkp_valid) begin
                rsp_hit   <= lkp_hit;
                rsp_taken <= lkp_taken;
                rsp_skip  <= lkp_skip;
                rsp_hist  <= ghr_q;
            end
            if (upd_valid) begin
                tbl_q[upd_idx] <= upd_next;
                ghr_q          <= {ghr_q[HIST_W-2:0], upd_taken};
            end
        end
    end

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
        lkp_valid |=> rsp_valid && (rsp_hist == $past(ghr_q))); // R2

    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_taken && rsp_skip == '0)); // R4

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        upd_valid |=> (ghr_q[0] == $past(upd_taken)) &&
                      (ghr_q[HIST_W-1:1] == $past(ghr_q[HIST_W-2:0]))); // R9

    AST_ALLOC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_hit) |=> tbl_q[$past(upd_idx)].valid &&
                                    (tbl_q[$past(upd_idx)].conf == '0)); // R6

    AST_HOLD_HIST: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(ghr_q)); // R9
endmodule

// File: tb/test_rcp_top.sv
module test_rcp_top;
    localparam int HIST_W = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lkp_valid = 1'b0;
    logic [31:0] lkp_pc = '0;
    logic rsp_valid, rsp_hit, rsp_taken;
    logic [15:0] rsp_skip;
    logic [HIST_W-1:0] rsp_hist;
    logic upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [HIST_W-1:0] upd_hist = '0;
    logic upd_taken = 1'b0;
    logic [15:0] upd_removable = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rcp_top #(.IDX_W(6), .HIST_W(HIST_W)) i_rcp_top (
        .clk(clk), .rst(rst), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_taken(rsp_taken),
        .rsp_skip(rsp_skip), .rsp_hist(rsp_hist), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_taken(upd_taken),
        .upd_removable(upd_removable));

    // Index = pc[7:2] ^ hist: A and D share index 0 with different tags,
    // B is index 1, E index 2, F index 3.
    localparam logic [31:0] PC_A = 32'h0000_1000;
    localparam logic [31:0] PC_B = 32'h0000_2004;
    localparam logic [31:0] PC_D = 32'h0000_1100;
    localparam logic [31:0] PC_E = 32'h0000_3008;
    localparam logic [31:0] PC_F = 32'h0000_400C;

    typedef struct packed {
        logic        is_upd;
        logic [31:0] pc;
        logic        taken;
        logic [15:0] rem;
        logic        e_hit;
        logic        e_taken;
        logic [15:0] e_mask;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{1'b0, PC_A, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000}, // R4 miss default
        '{1'b1, PC_A, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0000}, // R6 allocate
        '{1'b0, PC_A, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R6 weak not-taken, cleared
        '{1'b1, PC_A, 1'b0, 16'hFFFF, 1'b0, 1'b0, 16'h0000}, // R7 conf to 1
        '{1'b0, PC_A, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000}, // R5 counter 0
        '{1'b0, PC_B, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000}  // R3 other index misses
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_update(input logic [31:0] pc, input logic [HIST_W-1:0] h,
                             input logic t, input logic [15:0] rem);
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t; upd_removable = rem;
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] pc);
        @(negedge clk);
        lkp_valid = 1'b1; lkp_pc = pc;
        @(posedge clk); #1;
        lkp_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic h, input logic t, input logic [15:0] m);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " hit"}, 32'(rsp_hit), 32'(h));
        check({req, " taken"}, 32'(rsp_taken), 32'(t));
        check({req, " mask"}, 32'(rsp_skip), 32'(m));
    endtask

    task automatic flush_hist();
        for (int k = 0; k < HIST_W; k++) do_update(PC_F, '0, 1'b0, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

        // Vector table: all updates not-taken with history 0, so the history stays 0.
        for (int v = 0; v < 6; v++) begin
            if (VEC[v].is_upd)
                do_update(VEC[v].pc, '0, VEC[v].taken, VEC[v].rem);
            else begin
                do_lookup(VEC[v].pc);
                expect_rsp($sformatf("R3/R4/R6 row %0d", v), VEC[v].e_hit, VEC[v].e_taken, VEC[v].e_mask);
                check("R1 R2 hist zero", 32'(rsp_hist), 32'd0);
            end
        end

        // R8: bring slot counters from 1 to 63, threshold not yet reached
        for (int k = 0; k < 62; k++) do_update(PC_A, '0, 1'b0, 16'hFFFF);
        do_lookup(PC_A);
        expect_rsp("R8 at 63", 1'b1, 1'b0, 16'h0000);

        // R10: lookup together with the 64th update sees the old state
        @(negedge clk);
        lkp_valid = 1'b1; lkp_pc = PC_A;
        upd_valid = 1'b1; upd_pc = PC_A; upd_hist = '0; upd_taken = 1'b0; upd_removable = 16'hFFFF;
        @(posedge clk); #1;
        lkp_valid = 1'b0; upd_valid = 1'b0;
        expect_rsp("R10 same-cycle", 1'b1, 1'b0, 16'h0000);
        do_lookup(PC_A);
        expect_rsp("R8 at 64", 1'b1, 1'b0, 16'hFFFF);

        // R7: saturation, no wrap after 70 more removable reports
        for (int k = 0; k < 70; k++) do_update(PC_A, '0, 1'b0, 16'hFFFF);
        do_lookup(PC_A);
        expect_rsp("R7 saturate", 1'b1, 1'b0, 16'hFFFF);

        // R7: a non-removable report clears slot 0 only
        do_update(PC_A, '0, 1'b0, 16'hFFFE);
        do_update(PC_A, '0, 1'b0, 16'hFFFF);
        do_lookup(PC_A);
        expect_rsp("R7 clear slot0", 1'b1, 1'b0, 16'hFFFE);

        // R6: D aliases A's index with another tag; taken allocation -> weak taken
        do_update(PC_D, '0, 1'b1, 16'hFFFF);
        flush_hist();
        do_lookup(PC_A);
        expect_rsp("R6 evicted", 1'b0, 1'b1, 16'h0000);
        do_lookup(PC_D);
        expect_rsp("R6 realloc", 1'b1, 1'b1, 16'h0000);

        // R9 / R3: history shifts, lookup index moves with it
        do_update(PC_F, '0, 1'b1, 16'h0000);
        do_update(PC_F, '0, 1'b0, 16'h0000);
        do_update(PC_F, '0, 1'b1, 16'h0000);
        do_lookup(PC_F);
        check("R9 history", 32'(rsp_hist), 32'h05);
        check("R3 shifted index misses", 32'(rsp_hit), 32'd0);
        flush_hist();
        do_lookup(PC_F);
        check("R3 index hist 0 hits", 32'(rsp_hit), 32'd1);
        check("R9 flushed history", 32'(rsp_hist), 32'd0);

        // R5: direction counter stepping
        do_update(PC_E, '0, 1'b1, 16'h0000);  // alloc 2
        do_update(PC_E, '0, 1'b1, 16'h0000);  // 3
        do_update(PC_E, '0, 1'b1, 16'h0000);  // stays 3
        do_update(PC_E, '0, 1'b0, 16'h0000);  // 2
        flush_hist();
        do_lookup(PC_E);
        expect_rsp("R5 counter 2", 1'b1, 1'b1, 16'h0000);
        do_update(PC_E, '0, 1'b0, 16'h0000);  // 1
        do_lookup(PC_E);
        expect_rsp("R5 counter 1", 1'b1, 1'b0, 16'h0000);

        // R1: reset clears the table and history
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1 rst = 1'b0;
        check("R1 valid low", 32'(rsp_valid), 32'd0);
        do_lookup(PC_E);
        expect_rsp("R1 table empty", 1'b0, 1'b1, 16'h0000);
        check("R1 history zero", 32'(rsp_hist), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule